// File: doc/BRIEF.md
# Row-then-Column Event Address Sender

This block is the transmit-side controller of an array of event-generating pixels. Each pixel can signal an event. The block latches each event into a pending bitmap, with one bit per pixel. It picks one pending pixel in two stages. First it chooses a row from the per-row OR of the pending bits and registers that row's y coordinate. Then it chooses a column, looking only at the pending bits of the row it just chose, and registers the x coordinate. Because the column stage never looks at rows that were not chosen, the pair put on the bus is always a real pending pixel. It can never mix the coordinates of two contending pixels.

Once both coordinates are registered, the block raises a bus request to the receiver and runs a four-phase handshake. When the acknowledge rises, the block drops the request and clears the served pixel's pending bit. It also pulses that pixel's clear strobe for one cycle. All arbitration state then returns to idle. A new transfer starts only after the acknowledge has been seen low. The next choice is made afresh from the whole bitmap, so a row does not keep any priority from one transfer to the next.

Top module: `aer2d_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_req is 0 and pix_clr is all zero.
- R2: Pixel (row r, column c) is bit r*COLS+c of pix_req and pix_clr. The row served is the lowest-numbered row that holds any pending pixel.
- R3: The column served is the lowest-numbered pending column within the chosen row. The pair (x_addr, y_addr) is always a pixel that is actually pending.
- R4: x_addr and y_addr stay unchanged from the cycle bus_req rises until the acknowledge is taken.
- R5: bus_req falls on the clock edge after ack is seen high. It does not rise again while ack remains high.
- R6: When bus_req falls, pix_clr holds a single-cycle one-hot pulse at bit y_addr*COLS+x_addr.
- R7: A pix_req pulse that arrives during a transfer is latched and served in a later transfer. Every event is served exactly once.
- R8: Arbitration restarts from the whole bitmap after every transfer. A lower row that becomes pending during a transfer is served before the remaining pixels of the row just served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_req | input | ROWS*COLS | Per-pixel event pulses, bit r*COLS+c |
| ack | input | 1 | Receiver acknowledge |
| x_addr | output | log2(COLS) | Column address on the bus |
| y_addr | output | log2(ROWS) | Row address on the bus |
| bus_req | output | 1 | Request to the receiver |
| pix_clr | output | ROWS*COLS | One-cycle clear strobe for the served pixel |

## Verification
The bench works on a 4x4 array. It sweeps every single pixel and every pair of pixels raised together. A design that arbitrated the two dimensions independently would emit a ghost address, or serve the pair in the wrong order. The bench raises a lower row during a transfer. A design that kept the served row selected would then serve the rest of that row first. The bench also holds the acknowledge high after a transfer while a new event is pending. A design that skipped the return-to-zero phase would raise a request too early. Dropped or duplicated events show up as a missing or extra transfer.

// File: rtl/aer2d_pkg.sv
package aer2d_pkg;
  // handshake phases of one transfer
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // wait for ack low and a pending row
    ST_COL  = 2'd1,  // row latched, choose column
    ST_REQ  = 2'd2,  // request high, wait for ack
    ST_DONE = 2'd3   // request low, wait for ack to fall
  } tx_state_t;
endpackage

// File: rtl/aer_lsb_pick.sv
module aer_lsb_pick #(
  parameter int N = 64,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         hit
);
  // lowest set index wins
  always_comb begin
    idx = '0;
    hit = |vec;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/aer_pend_map.sv
module aer_pend_map #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  localparam int NPIX = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIX-1:0] set_vec,
  input  logic [NPIX-1:0] clr_vec,
  output logic [NPIX-1:0] pend,
  output logic [ROWS-1:0] row_any
);
  // a new event in the same cycle as a clear survives
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_vec) | set_vec;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_any[r] = |pend[r*COLS +: COLS];
  end
endmodule

// File: rtl/aer2d_tx.sv
module aer2d_tx
  import aer2d_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  localparam int XW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int YW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NPIX = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIX-1:0] pix_req,
  input  logic            ack,
  output logic [XW-1:0]   x_addr,
  output logic [YW-1:0]   y_addr,
  output logic            bus_req,
  output logic [NPIX-1:0] pix_clr
);
  tx_state_t       state;
  logic [NPIX-1:0] pend;
  logic [ROWS-1:0] row_any;
  logic [COLS-1:0] row_bits;
  logic [NPIX-1:0] clr_now;
  logic [YW-1:0]   row_idx;
  logic [XW-1:0]   col_idx;
  logic            row_hit, col_hit;

  aer_pend_map #(.ROWS(ROWS), .COLS(COLS)) u_pend (
    .clk(clk), .rst(rst), .set_vec(pix_req), .clr_vec(clr_now),
    .pend(pend), .row_any(row_any)
  );

  // stage 1: rows
  aer_lsb_pick #(.N(ROWS), .W(YW)) u_row_pick (
    .vec(row_any), .idx(row_idx), .hit(row_hit)
  );

  // stage 2: only the latched row takes part
  assign row_bits = pend[int'(y_addr)*COLS +: COLS];

  aer_lsb_pick #(.N(COLS), .W(XW)) u_col_pick (
    .vec(row_bits), .idx(col_idx), .hit(col_hit)
  );

  // clear the served pixel when ack is taken
  always_comb begin
    clr_now = '0;
    if (state == ST_REQ && ack)
      clr_now[int'(y_addr)*COLS + int'(x_addr)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      x_addr  <= '0;
      y_addr  <= '0;
      bus_req <= 1'b0;
      pix_clr <= '0;
    end else begin
      pix_clr <= clr_now;
      case (state)
        ST_IDLE: if (!ack && row_hit) begin
          y_addr <= row_idx;
          state  <= ST_COL;
        end
        ST_COL: if (col_hit) begin
          x_addr  <= col_idx;
          bus_req <= 1'b1;
          state   <= ST_REQ;
        end else begin
          state <= ST_IDLE;
        end
        ST_REQ: if (ack) begin
          bus_req <= 1'b0;
          state   <= ST_DONE;
        end
        ST_DONE: if (!ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aer2d_tx_chk.sv
module aer2d_tx_chk #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  localparam int XW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int YW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NPIX = ROWS * COLS
) (
  input logic            clk,
  input logic            rst,
  input logic            ack,
  input logic            bus_req,
  input logic [XW-1:0]   x_addr,
  input logic [YW-1:0]   y_addr,
  input logic [NPIX-1:0] pix_clr
);
  p_clr_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pix_clr));

  p_clr_with_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (|pix_clr) |-> $fell(bus_req));

  p_clr_hits_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (|pix_clr) |-> pix_clr[int'(y_addr)*COLS + int'(x_addr)]);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(bus_req)) |-> ($stable(x_addr) && $stable(y_addr)));

  p_req_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && ack) |=> !bus_req);

  p_no_rise_on_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (!bus_req && ack) |=> !bus_req);
endmodule

bind aer2d_tx aer2d_tx_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .bus_req(bus_req),
  .x_addr(x_addr), .y_addr(y_addr), .pix_clr(pix_clr)
);

// File: tb/aer2d_tx_tb.sv
module aer2d_tx_tb;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int XW   = $clog2(COLS);
  localparam int YW   = $clog2(ROWS);
  localparam int NPIX = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NPIX-1:0] pix_req = '0;
  logic            ack = 1'b0;
  logic [XW-1:0]   x_addr;
  logic [YW-1:0]   y_addr;
  logic            bus_req;
  logic [NPIX-1:0] pix_clr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  aer2d_tx #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst(rst), .pix_req(pix_req), .ack(ack),
    .x_addr(x_addr), .y_addr(y_addr), .bus_req(bus_req), .pix_clr(pix_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse2(input int a, input int b);
    pix_req = '0;
    if (a >= 0) pix_req[a] = 1'b1;
    if (b >= 0) pix_req[b] = 1'b1;
    @(negedge clk);
    pix_req = '0;
  endtask

  // one four-phase transfer expecting pixel ex; ack held hold_ack extra cycles
  task automatic xfer(input int ex, input int hold_ack, input int late);
    int n = 0;
    logic [XW-1:0] x0;
    logic [YW-1:0] y0;
    while (!bus_req && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(bus_req === 1'b1, "R7 request raised", int'(bus_req), 1);
    x0 = x_addr;
    y0 = y_addr;
    chk(int'(y0) == ex / COLS, "R2 row address", int'(y0), ex / COLS);
    chk(int'(x0) == ex % COLS, "R3 column address", int'(x0), ex % COLS);
    if (late >= 0) pulse2(late, -1);
    else @(negedge clk);
    @(negedge clk);
    chk(x_addr == x0 && y_addr == y0, "R4 address stable",
        int'(y_addr) * COLS + int'(x_addr), int'(y0) * COLS + int'(x0));
    ack = 1'b1;
    @(negedge clk);
    chk(bus_req === 1'b0, "R5 request dropped", int'(bus_req), 0);
    chk(pix_clr == (NPIX'(1) << ex), "R6 clear strobe", int'(pix_clr), 1 << ex);
    @(negedge clk);
    chk(pix_clr == '0, "R6 strobe one cycle", int'(pix_clr), 0);
    for (int i = 0; i < hold_ack; i++) begin
      @(negedge clk);
      chk(bus_req === 1'b0, "R5 no request while ack high", int'(bus_req), 0);
    end
    ack = 1'b0;
  endtask

  task automatic quiet(input string req);
    bit seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (bus_req) seen = 1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req === 1'b0 && pix_clr == '0, "R1 reset state", int'(bus_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_req === 1'b0 && pix_clr == '0, "R1 after reset", int'(bus_req), 0);

    // every single pixel
    for (int p = 0; p < NPIX; p++) begin
      pulse2(p, -1);
      xfer(p, 0, -1);
      quiet("R7 single served once");
    end

    // every pair raised together: linear order equals row-then-column order
    for (int a = 0; a < NPIX; a++) begin
      for (int b = a + 1; b < NPIX; b++) begin
        pulse2(a, b);
        xfer(a, 0, -1);
        xfer(b, 0, -1);
        @(negedge clk);
        @(negedge clk);
        chk(bus_req === 1'b0, "R3 no ghost third transfer", int'(bus_req), 0);
      end
    end

    // R8: lower row arrives mid-transfer and beats rest of served row
    pulse2(9, 11);
    xfer(9, 0, 0);
    xfer(0, 0, -1);
    xfer(11, 0, -1);
    quiet("R7 late pixels served once");

    // R5: ack held high with a new event pending
    pulse2(5, -1);
    xfer(5, 0, 6);
    ack = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(bus_req === 1'b0, "R5 wait for ack low", int'(bus_req), 0);
    end
    ack = 1'b0;
    xfer(6, 0, -1);
    quiet("R7 nothing left");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule